// File: doc/BRIEF.md
# Host-Written Transmit Frame Assembler

This block gathers an outgoing frame that a host supplies one byte per register write, then plays the frame out on a byte-wide valid/ready stream. The host first programs the expected frame length, then writes the frame bytes one at a time. There is no start command. Transmission begins by itself on the write that brings the byte count up to the programmed length, or up to the buffer capacity. A length outside the legal range is stored as zero, and a zero length means "send when the buffer is full".

When a frame is launched, the block pulses a transmit-done event and a busy-set request for one cycle. It also returns the length register and the write counter to zero. The outbound stream follows the usual back-pressure rules. Once `m_valid` is high, it stays high and `m_data`/`m_last` stay unchanged until the sink raises `m_ready`. A byte leaves on every clock edge where both signals are high. Data writes that arrive while a frame is still leaving are dropped, which protects the buffer from corruption.

Top module: `txasm_top`

## Requirements
- R1: After reset, `m_valid`, `m_last`, `tx_done` and `busy_set` are 0 and `len_rdata` reads 0.
- R2: A length write stores `wdata` when it is at most MAX_FRAME (default 1514) and stores 0 otherwise. The stored value appears on `len_rdata` in the cycle after the write.
- R3: A length write sets the count of bytes written back to zero, so bytes written before it are not part of the next frame.
- R4: A data write stores `wdata[7:0]` at the current write position and advances that position. Upper bits of `wdata` are not used.
- R5: The write that makes the byte count equal to a nonzero programmed length launches the frame. In the cycle after that write, `len_rdata` reads 0 and the next frame starts at position 0.
- R6: When the programmed length is 0, the frame launches on the MAX_FRAME-th data write and not before.
- R7: `tx_done` and `busy_set` are each high for exactly one cycle: the cycle after the launching write, which is also the first cycle of `m_valid`.
- R8: The stream presents the bytes in write order. `m_last` is high on the final byte only. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values.
- R9: A data write made while `m_valid` is high is ignored. It does not change the buffer or the write position, and it does not launch a frame.
- R10: `data_rdata`, the read value of the data register, is always 0.
- R11: When `len_we` and `data_we` are high in the same cycle, only the length write takes effect and no byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_we | input | 1 | Write strobe for the length register |
| data_we | input | 1 | Write strobe for the data register |
| wdata | input | WDATA_W | Write data shared by both registers |
| len_rdata | output | WDATA_W | Current length register value, zero-extended |
| data_rdata | output | WDATA_W | Read value of the data register (always 0) |
| m_valid | output | 1 | Outbound byte valid |
| m_ready | input | 1 | Outbound sink ready |
| m_data | output | 8 | Outbound byte |
| m_last | output | 1 | Marks the final byte of the frame |
| tx_done | output | 1 | One-cycle transmit-done event |
| busy_set | output | 1 | One-cycle request to set the device busy flag |

## Verification
Every register write takes effect on the clock edge that samples it. A length write is therefore visible on `len_rdata` in the following cycle. A launching data write raises `tx_done`, `busy_set` and `m_valid`, and presents byte 0, in the cycle right after that write. Each later byte appears in the cycle after a handshake edge. The bench drives inputs on the falling edge and compares outputs at the next falling edge, so each expected value is read exactly one edge after the stimulus that caused it. Stall cycles re-check the same expected byte, which confirms the data holds steady under back-pressure.

// File: rtl/txasm_pkg.sv
package txasm_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/txasm_len_reg.sv
module txasm_len_reg #(
  parameter int MAX_FRAME = 1514,
  parameter int WDATA_W   = 32,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_we,
  input  logic [WDATA_W-1:0] wdata,
  input  logic               clear,
  output logic [CNT_W-1:0]   len_q
);
  logic in_range;
  assign in_range = (wdata <= WDATA_W'(MAX_FRAME));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= in_range ? wdata[CNT_W-1:0] : '0;
    end else if (clear) begin
      len_q <= '0;
    end
  end
endmodule

// File: rtl/txasm_fill_ctrl.sv
module txasm_fill_ctrl #(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic             data_we,
  input  logic             streaming,
  input  logic [CNT_W-1:0] len_q,
  output logic [CNT_W-1:0] wr_idx,
  output logic             mem_we,
  output logic             fire,
  output logic [CNT_W-1:0] fire_len
);
  logic [CNT_W-1:0] nxt;

  assign mem_we   = data_we && !len_we && !streaming;
  assign nxt      = wr_idx + 1'b1;
  assign fire     = mem_we && ((nxt == len_q) || (nxt == CNT_W'(MAX_FRAME)));
  assign fire_len = nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
    end else if (len_we || fire) begin
      wr_idx <= '0;
    end else if (mem_we) begin
      wr_idx <= nxt;
    end
  end
endmodule

// File: rtl/txasm_buf.sv
module txasm_buf
  import txasm_pkg::*;
#(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CNT_W-1:0] wr_idx,
  input  byte_t            wr_byte,
  input  logic [CNT_W-1:0] rd_idx,
  output byte_t            rd_byte
);
  byte_t mem [MAX_FRAME];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/txasm_stream.sv
module txasm_stream #(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] fire_len,
  input  logic             m_ready,
  output logic             active,
  output logic             last,
  output logic [CNT_W-1:0] rd_idx,
  output logic             done_pulse
);
  logic [CNT_W-1:0] frame_len;

  assign last = active && (rd_idx == frame_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      rd_idx     <= '0;
      frame_len  <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= fire;
      if (fire) begin
        active    <= 1'b1;
        rd_idx    <= '0;
        frame_len <= fire_len;
      end else if (active && m_ready) begin
        if (last) begin
          active <= 1'b0;
          rd_idx <= '0;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/txasm_top.sv
module txasm_top
  import txasm_pkg::*;
#(
  parameter int MAX_FRAME = 1514,
  parameter int WDATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_we,
  input  logic               data_we,
  input  logic [WDATA_W-1:0] wdata,
  output logic [WDATA_W-1:0] len_rdata,
  output logic [WDATA_W-1:0] data_rdata,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [7:0]         m_data,
  output logic               m_last,
  output logic               tx_done,
  output logic               busy_set
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);

  logic [CNT_W-1:0] len_q, wr_idx, fire_len, rd_idx;
  logic             mem_we, fire, active, last, done_pulse;
  byte_t            rd_byte;

  txasm_len_reg #(.MAX_FRAME(MAX_FRAME), .WDATA_W(WDATA_W), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .wdata(wdata),
    .clear(fire), .len_q(len_q)
  );

  txasm_fill_ctrl #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .data_we(data_we),
    .streaming(active), .len_q(len_q), .wr_idx(wr_idx), .mem_we(mem_we),
    .fire(fire), .fire_len(fire_len)
  );

  txasm_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .we(mem_we), .wr_idx(wr_idx), .wr_byte(wdata[7:0]),
    .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  txasm_stream #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_str (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_len(fire_len),
    .m_ready(m_ready), .active(active), .last(last), .rd_idx(rd_idx),
    .done_pulse(done_pulse)
  );

  assign len_rdata  = WDATA_W'(len_q);
  assign data_rdata = '0;
  assign m_valid    = active;
  assign m_data     = rd_byte;
  assign m_last     = last;
  assign tx_done    = done_pulse;
  assign busy_set   = done_pulse;
endmodule

// File: rtl/txasm_chk.sv
module txasm_chk #(
  parameter int MAX_FRAME = 1514,
  parameter int WDATA_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               m_valid,
  input logic               m_ready,
  input logic [7:0]         m_data,
  input logic               m_last,
  input logic               tx_done,
  input logic               busy_set,
  input logic [WDATA_W-1:0] len_rdata
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R7
  done_starts_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || busy_set) |-> m_valid);

  // R5
  len_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (len_rdata == '0));

  // R9
  no_launch_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !tx_done);

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_rdata <= WDATA_W'(MAX_FRAME));
endmodule

bind txasm_top txasm_chk #(.MAX_FRAME(MAX_FRAME), .WDATA_W(WDATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last), .tx_done(tx_done), .busy_set(busy_set),
  .len_rdata(len_rdata)
);

// File: tb/tb_txasm_top.sv
`timescale 1ns/1ps
module tb_txasm_top;
  localparam int MAXF = 1514;
  localparam int WW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          len_we = 1'b0, data_we = 1'b0, m_ready = 1'b0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] len_rdata, data_rdata;
  logic          m_valid, m_last, tx_done, busy_set;
  logic [7:0]    m_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_b [0:2047];

  always #2.5 clk = ~clk;

  txasm_top #(.MAX_FRAME(MAXF), .WDATA_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .data_we(data_we),
    .wdata(wdata), .len_rdata(len_rdata), .data_rdata(data_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .tx_done(tx_done), .busy_set(busy_set)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr_len(input logic [WW-1:0] v);
    @(negedge clk); len_we = 1'b1; wdata = v;
    @(negedge clk); len_we = 1'b0;
  endtask

  task automatic wr_byte(input logic [WW-1:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  // stall_mode 0: always ready; 1: alternate; 2: two stalls per byte
  task automatic drain(input int n, input int stall_mode, input string req);
    int k = 0;
    int t = 0;
    while (k < n && t < 20000) begin
      logic rdy;
      rdy = (stall_mode == 0) ? 1'b1 : (stall_mode == 1) ? t[0] : (t % 3 == 2);
      m_ready = rdy;
      chk(m_valid === 1'b1, req, m_valid, 1);
      chk(m_data === exp_b[k], req, m_data, exp_b[k]);
      chk(m_last === (k == n - 1), {req, " last"}, m_last, (k == n - 1));
      if (rdy) k++;
      t++;
      @(negedge clk);
    end
    m_ready = 1'b0;
    chk(m_valid === 1'b0, {req, " end"}, m_valid, 0);
  endtask

  task automatic t_reset;
    chk(m_valid === 1'b0, "R1 valid", m_valid, 0);
    chk(m_last === 1'b0, "R1 last", m_last, 0);
    chk(tx_done === 1'b0 && busy_set === 1'b0, "R1 events", tx_done, 0);
    chk(len_rdata === 0, "R1 len", len_rdata, 0);
    chk(data_rdata === 0, "R10 data read", data_rdata, 0);
  endtask

  task automatic t_len_clamp;
    wr_len(MAXF);    chk(len_rdata === MAXF, "R2 max", len_rdata, MAXF);
    wr_len(MAXF + 1); chk(len_rdata === 0, "R2 over", len_rdata, 0);
    wr_len(7);       chk(len_rdata === 7, "R2 small", len_rdata, 7);
    wr_len(32'h0001_0005); chk(len_rdata === 0, "R2 high bits", len_rdata, 0);
  endtask

  task automatic t_basic;
    wr_len(4);
    for (int i = 0; i < 4; i++) begin
      exp_b[i] = 8'hA1 + 8'(i);
      wr_byte(32'hFFFF_FF00 | 32'(exp_b[i]));
      if (i < 3) chk(tx_done === 1'b0 && m_valid === 1'b0, "R5 early", tx_done, 0);
    end
    chk(tx_done === 1'b1, "R7 tx_done", tx_done, 1);
    chk(busy_set === 1'b1, "R7 busy_set", busy_set, 1);
    chk(len_rdata === 0, "R5 len cleared", len_rdata, 0);
    chk(data_rdata === 0, "R10 data read", data_rdata, 0);
    @(negedge clk);
    chk(tx_done === 1'b0 && busy_set === 1'b0, "R7 single", tx_done, 0);
    drain(4, 0, "R4 R8 basic");
  endtask

  task automatic t_restart;
    wr_len(5);
    wr_byte(32'h11); wr_byte(32'h22);
    wr_len(3);
    exp_b[0] = 8'h31; exp_b[1] = 8'h32; exp_b[2] = 8'h33;
    wr_byte(32'h31); wr_byte(32'h32);
    chk(tx_done === 1'b0, "R3 no early", tx_done, 0);
    wr_byte(32'h33);
    chk(tx_done === 1'b1, "R3 launch", tx_done, 1);
    drain(3, 0, "R3 frame");
  endtask

  task automatic t_stall;
    wr_len(5);
    for (int i = 0; i < 5; i++) begin
      exp_b[i] = 8'h5C ^ 8'(i * 37);
      wr_byte(32'(exp_b[i]));
    end
    drain(5, 1, "R8 alt stall");
    wr_len(3);
    for (int i = 0; i < 3; i++) begin
      exp_b[i] = 8'(200 + i);
      wr_byte(32'(exp_b[i]));
    end
    drain(3, 2, "R8 long stall");
  endtask

  task automatic t_ignore;
    wr_len(2);
    exp_b[0] = 8'h11; exp_b[1] = 8'h22;
    wr_byte(32'h11); wr_byte(32'h22);
    for (int i = 0; i < 3; i++) begin
      wr_byte(32'h99);
      chk(tx_done === 1'b0, "R9 no launch", tx_done, 0);
    end
    drain(2, 0, "R9 frame intact");
    wr_len(1);
    exp_b[0] = 8'h33;
    wr_byte(32'h33);
    chk(tx_done === 1'b1, "R9 index unchanged", tx_done, 1);
    drain(1, 0, "R9 next frame");
  endtask

  task automatic t_full;
    wr_len(MAXF + 200);
    for (int i = 0; i < MAXF; i++) begin
      exp_b[i] = 8'(i * 7 + 3);
      wr_byte(32'(exp_b[i]));
      if (i == MAXF - 2) chk(tx_done === 1'b0, "R6 not before full", tx_done, 0);
    end
    chk(tx_done === 1'b1, "R6 launch at full", tx_done, 1);
    drain(MAXF, 0, "R6 full frame");
  endtask

  task automatic t_collide;
    wr_len(3);
    @(negedge clk); len_we = 1'b1; data_we = 1'b1; wdata = 32'd1;
    @(negedge clk); len_we = 1'b0; data_we = 1'b0;
    chk(len_rdata === 1, "R11 len wins", len_rdata, 1);
    chk(tx_done === 1'b0, "R11 no byte", tx_done, 0);
    exp_b[0] = 8'h5A;
    wr_byte(32'h5A);
    chk(tx_done === 1'b1, "R11 launch", tx_done, 1);
    drain(1, 0, "R11 frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_len_clamp();
    t_basic();
    t_restart();
    t_stall();
    t_ignore();
    t_full();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule